// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves single characters over the one shared, open-drain data line between a reader and a smart card. It runs half duplex: in receive mode it watches for a falling start edge, samples ten bit cells and places the data byte in an eight-entry receive queue. In transmit mode it sends one buffered byte as a framed character and then listens for the card's rejection pulse. All timing is counted in quarters of an elementary time unit (ETU). A programmable clock divider sets how many clock cycles make one quarter.

Two protocol flavours are supported, and they differ in how they treat parity. In the character protocol (T=0), a receive parity error is signalled back to the card by holding the line low, and the character is discarded. A card rejection of a transmitted character is counted, and a hardware guard window keeps the host from reloading the rejected byte too early. In the block protocol (T=1), parity errors are neither signalled nor counted, and the character is still queued. A read-clear status byte reports sticky error flags, together with a buffer flag whose meaning follows the current direction.

Top module: `scCharEngine`

## Requirements
- R1: A character is a low start bit, eight data bits least significant first, and a parity bit that makes the nine data and parity bits hold an even number of ones. One quarter ETU lasts cfgQtrDiv clocks. The receiver samples bit k in the middle of its cell, 4k+2 quarters after it detects the start edge.
- R2: In receive mode with cfgT1=0, a character with bad parity is not queued. ioDriveLow is held high from 42 to 46 quarters (10.5 to 11.5 ETU) after the start edge.
- R3: With cfgT1=1, a character with bad parity is queued like a good one, ioDriveLow stays low, and status bit 3 is not raised.
- R4: The receive queue holds 8 characters in arrival order. rxData shows the oldest entry, and a one-cycle hostRxRead pulse removes it. In receive mode (modeTx=0), status bit 0 is 1 exactly while the queue is full.
- R5: Status bit 2 (overrun) sets when a character that would be queued completes while the queue is full. That character is lost and the queued ones are kept.
- R6: Status bit 1 (framing) sets when the line is low 41 quarters (10.25 ETU) after a received start edge. A hostStatusRead pulse clears status bits 3, 2 and 1 and the parity-error count. The status byte is 0 after reset.
- R7: With cfgT1=0, each receive parity error and each card rejection of a transmitted character increments a 3-bit count. Status bit 3 sets when the count reaches cfgPeLimit. In receive the flag rises on the clock edge 42 quarters after the start edge; in transmit it rises 46 quarters after the start edge.
- R8: In transmit mode (modeTx=1), status bit 0 reads as transmit-buffer-empty. Setting the mode makes it 1, and an accepted hostTxWrite clears it. The character is then sent without further action. The flag returns to 1 when the character ends, 48 quarters after its start.
- R9: With cfgT1=0, the transmitter samples the line 44 quarters after its start edge. If the line is low, the card has rejected the character and nakGuard stays high for 54 quarters (13.5 ETU). hostTxWrite is ignored while nakGuard is high.
- R10: If cfgLastChar is 1 when a character starts and the character is not rejected, modeTx clears at its end and transmit-buffer-empty is not set. Clearing the mode through hostModeWr also clears transmit-buffer-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgQtrDiv | input | 10 | Clock cycles per quarter ETU |
| cfgT1 | input | 1 | 1 selects block protocol, 0 character protocol |
| cfgPeLimit | input | 3 | Parity-error count that raises status bit 3 |
| cfgLastChar | input | 1 | Marks the next transmitted character as the last |
| hostModeWr | input | 1 | Strobe that writes the direction |
| hostModeVal | input | 1 | Direction written by hostModeWr, 1 for transmit |
| hostTxWrite | input | 1 | Strobe that loads hostTxData |
| hostTxData | input | 8 | Byte to transmit |
| hostRxRead | input | 1 | Strobe that removes the oldest queued byte |
| hostStatusRead | input | 1 | Strobe that clears the sticky status flags |
| ioIn | input | 1 | Sensed level of the card data line |
| ioDriveLow | output | 1 | Pulls the card data line low when 1 |
| rxData | output | 8 | Oldest queued byte |
| status | output | 8 | {4'b0, parity, overrun, framing, buffer flag} |
| modeTx | output | 1 | Current direction, 1 for transmit |
| nakGuard | output | 1 | High while the post-rejection window runs |

## Verification
The receiver is driven with fixed bytes whose parity bit is correct and bytes whose parity bit is flipped, under both protocol settings. This separates the drop-and-signal behaviour from the store-silently behaviour, and shows the parity count advancing only in the first case. A run of random bytes with random parity under the block protocol fills the queue past its depth, which shows ordering, the full flag and the loss of exactly the surplus character. A character with a stop bit held low separates framing detection from parity handling. On the transmit side, random bytes are decoded by a card model. One character is rejected and then rewritten inside and after the guard window, and a last-character transfer shows the direction dropping without the empty flag.

// File: rtl/scCharPkg.sv
package scCharPkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} engStateT;

  // Quarter-ETU instants, counted from the start edge
  localparam logic [5:0] QT_DATA_END = 6'd40;  // line released after parity cell
  localparam logic [5:0] QT_FRAME    = 6'd41;  // framing sample (10.25 ETU)
  localparam logic [5:0] QT_DECIDE   = 6'd42;  // rx verdict, rx NAK start (10.5 ETU)
  localparam logic [5:0] QT_NAK_SMP  = 6'd44;  // tx rejection sample (11 ETU)
  localparam logic [5:0] QT_NAK_END  = 6'd46;  // rx NAK end, tx parity flag (11.5 ETU)
  localparam logic [5:0] QT_END      = 6'd48;  // character slot over (12 ETU)
  localparam logic [5:0] QT_GUARD    = 6'd54;  // rewrite window (13.5 ETU)

  typedef struct packed {
    logic       rxStart;
    logic       txLoad;
    logic       sampleBit;
    logic [3:0] bitIdx;
    logic       frameChk;
    logic       rxDecide;
    logic       nakSample;
    logic       txPeMark;
    logic       txDone;
  } ctrlStrobeT;

endpackage

// File: rtl/scCharCtrl.sv
module scCharCtrl
  import scCharPkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgQtrDiv,
  input  logic             cfgT1,
  input  logic             ioIn,
  input  logic             modeTx,
  input  logic             txFull,
  input  logic             txBit,
  input  logic             rxNak,
  output ctrlStrobeT       strb,
  output logic             ioDriveLow,
  output logic             nakGuard
);

  engStateT         state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   divNext;
  logic             qtick;
  logic [5:0]       q;
  logic [5:0]       qNext;
  logic             ioPrev;
  logic [5:0]       guardCnt;
  logic             rxStart;
  logic             txLoad;

  assign divNext  = {1'b0, divCnt} + 1'b1;
  assign qtick    = divNext >= {1'b0, cfgQtrDiv};
  assign qNext    = q + 6'd1;
  assign nakGuard = guardCnt != 6'd0;

  assign rxStart = (state == ST_IDLE) && !modeTx && ioPrev && !ioIn;
  assign txLoad  = (state == ST_IDLE) && modeTx && txFull && !nakGuard;

  always_comb begin
    strb           = '0;
    strb.rxStart   = rxStart;
    strb.txLoad    = txLoad;
    strb.bitIdx    = q[5:2];
    strb.sampleBit = (state == ST_RX) && qtick && (q[1:0] == 2'd1) && (q < QT_DATA_END);
    strb.frameChk  = (state == ST_RX) && qtick && (qNext == QT_FRAME);
    strb.rxDecide  = (state == ST_RX) && qtick && (qNext == QT_DECIDE);
    strb.nakSample = (state == ST_TX) && qtick && (qNext == QT_NAK_SMP) && !cfgT1;
    strb.txPeMark  = (state == ST_TX) && qtick && (qNext == QT_NAK_END);
    strb.txDone    = (state == ST_TX) && qtick && (qNext == QT_END);
  end

  assign ioDriveLow = ((state == ST_TX) && (q < QT_DATA_END) && !txBit) ||
                      ((state == ST_RX) && rxNak && (q >= QT_DECIDE) && (q < QT_NAK_END));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      q        <= '0;
      ioPrev   <= 1'b1;
      guardCnt <= '0;
    end else begin
      ioPrev <= ioIn;
      if (rxStart || txLoad || qtick) divCnt <= '0;
      else                            divCnt <= divNext[DIV_W-1:0];

      case (state)
        ST_IDLE: begin
          if (rxStart) begin
            state <= ST_RX;
            q     <= '0;
          end else if (txLoad) begin
            state <= ST_TX;
            q     <= '0;
          end
        end
        default: begin
          if (qtick) q <= qNext;
          if (qtick && (qNext == QT_END)) state <= ST_IDLE;
        end
      endcase

      if (strb.nakSample && !ioIn)         guardCnt <= QT_GUARD;
      else if (qtick && guardCnt != 6'd0)  guardCnt <= guardCnt - 6'd1;
    end
  end

endmodule

// File: rtl/scCharData.sv
module scCharData
  import scCharPkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int PE_W       = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobeT      strb,
  input  logic            ioIn,
  input  logic            cfgT1,
  input  logic [PE_W-1:0] cfgPeLimit,
  input  logic            cfgLastChar,
  input  logic            nakGuard,
  input  logic            hostModeWr,
  input  logic            hostModeVal,
  input  logic            hostTxWrite,
  input  logic [7:0]      hostTxData,
  input  logic            hostRxRead,
  input  logic            hostStatusRead,
  output logic            txFull,
  output logic            txBit,
  output logic            rxNak,
  output logic [7:0]      rxData,
  output logic [7:0]      status,
  output logic            modeTx
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0]   LAST_SLOT = AW'(FIFO_DEPTH - 1);
  localparam logic [PE_W-1:0] PE_MAX    = '1;

  logic [7:0]      txHold, txShift, rxShift;
  logic            txLast, tbe, nakSeen, rxPar;
  logic            flagPe, flagOvr, flagFer;
  logic [PE_W-1:0] peCount, peNext;
  logic [7:0]      fifoMem [FIFO_DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [CW-1:0]   fifoCnt;
  logic            fifoFull, fifoEmpty, parityBad, keepChar, push, pop;
  logic            peEvent, txAccept;

  assign fifoFull  = fifoCnt == CW'(FIFO_DEPTH);
  assign fifoEmpty = fifoCnt == '0;
  assign parityBad = ^{rxShift, rxPar};
  assign keepChar  = cfgT1 || !parityBad;
  assign push      = strb.rxDecide && keepChar && !fifoFull;
  assign pop       = hostRxRead && !fifoEmpty;
  assign peEvent   = (strb.rxDecide && parityBad && !cfgT1) || (strb.txPeMark && nakSeen);
  assign peNext    = (peCount == PE_MAX) ? peCount : peCount + 1'b1;
  assign txAccept  = hostTxWrite && modeTx && !nakGuard && !txFull;

  assign rxData = fifoMem[rdPtr];
  assign status = {4'b0000, flagPe, flagOvr, flagFer, modeTx ? tbe : fifoFull};

  always_comb begin
    case (strb.bitIdx)
      4'd0:    txBit = 1'b0;
      4'd9:    txBit = ^txShift;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8:
               txBit = txShift[3'(strb.bitIdx - 4'd1)];
      default: txBit = 1'b1;
    endcase
  end

  // Receive path, queue and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxPar   <= 1'b0;
      rxNak   <= 1'b0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
      flagPe  <= 1'b0;
      flagOvr <= 1'b0;
      flagFer <= 1'b0;
      peCount <= '0;
    end else begin
      if (strb.rxStart) rxNak <= 1'b0;
      if (strb.sampleBit) begin
        if (strb.bitIdx == 4'd9)      rxPar <= ioIn;
        else if (strb.bitIdx != 4'd0) rxShift[3'(strb.bitIdx - 4'd1)] <= ioIn;
      end
      if (strb.rxDecide) rxNak <= parityBad && !cfgT1;

      if (push) begin
        fifoMem[wrPtr] <= rxShift;
        wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      fifoCnt <= fifoCnt + CW'(push) - CW'(pop);

      if (hostStatusRead) begin
        flagPe  <= 1'b0;
        flagOvr <= 1'b0;
        flagFer <= 1'b0;
        peCount <= '0;
      end
      if (peEvent) begin
        peCount <= peNext;
        if (peNext == cfgPeLimit) flagPe <= 1'b1;
      end
      if (strb.rxDecide && keepChar && fifoFull) flagOvr <= 1'b1;
      if (strb.frameChk && !ioIn)                flagFer <= 1'b1;
    end
  end

  // Transmit holding register, direction and empty flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      txFull  <= 1'b0;
      txLast  <= 1'b0;
      tbe     <= 1'b0;
      nakSeen <= 1'b0;
      modeTx  <= 1'b0;
    end else begin
      if (strb.txLoad) begin
        txShift <= txHold;
        txFull  <= 1'b0;
        txLast  <= cfgLastChar;
        nakSeen <= 1'b0;
      end
      if (strb.nakSample) nakSeen <= !ioIn;
      if (strb.txDone) begin
        if (txLast && !nakSeen) begin
          modeTx <= 1'b0;
          tbe    <= 1'b0;
        end else begin
          tbe <= !txFull;
        end
      end
      if (txAccept) begin
        txHold <= hostTxData;
        txFull <= 1'b1;
        tbe    <= 1'b0;
      end
      if (hostModeWr) begin
        modeTx <= hostModeVal;
        tbe    <= hostModeVal && !txFull;
      end
    end
  end

endmodule

// File: rtl/scCharEngine.sv
module scCharEngine
  import scCharPkg::*;
#(
  parameter int DIV_W      = 10,
  parameter int FIFO_DEPTH = 8,
  parameter int PE_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgQtrDiv,
  input  logic             cfgT1,
  input  logic [PE_W-1:0]  cfgPeLimit,
  input  logic             cfgLastChar,
  input  logic             hostModeWr,
  input  logic             hostModeVal,
  input  logic             hostTxWrite,
  input  logic [7:0]       hostTxData,
  input  logic             hostRxRead,
  input  logic             hostStatusRead,
  input  logic             ioIn,
  output logic             ioDriveLow,
  output logic [7:0]       rxData,
  output logic [7:0]       status,
  output logic             modeTx,
  output logic             nakGuard
);

  ctrlStrobeT strb;
  logic       txFull, txBit, rxNak;

  scCharCtrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgQtrDiv(cfgQtrDiv), .cfgT1(cfgT1), .ioIn(ioIn),
    .modeTx(modeTx), .txFull(txFull), .txBit(txBit), .rxNak(rxNak),
    .strb(strb), .ioDriveLow(ioDriveLow), .nakGuard(nakGuard)
  );

  scCharData #(.FIFO_DEPTH(FIFO_DEPTH), .PE_W(PE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ioIn(ioIn), .cfgT1(cfgT1),
    .cfgPeLimit(cfgPeLimit), .cfgLastChar(cfgLastChar), .nakGuard(nakGuard),
    .hostModeWr(hostModeWr), .hostModeVal(hostModeVal), .hostTxWrite(hostTxWrite),
    .hostTxData(hostTxData), .hostRxRead(hostRxRead), .hostStatusRead(hostStatusRead),
    .txFull(txFull), .txBit(txBit), .rxNak(rxNak), .rxData(rxData),
    .status(status), .modeTx(modeTx)
  );

endmodule

// File: rtl/scCharChecker.sv
module scCharChecker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgT1,
  input logic       hostModeWr,
  input logic       hostTxWrite,
  input logic       hostRxRead,
  input logic       hostStatusRead,
  input logic       ioIn,
  input logic [7:0] status,
  input logic       modeTx,
  input logic       nakGuard
);

  a_r6_fer_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> $past(!ioIn));

  a_r7_pe_t0_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> $past(!cfgT1));

  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[2] && !hostStatusRead) |=> status[2]);

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!modeTx && status[0] && !hostRxRead && !hostModeWr) |=> status[0]);

  a_r8_write_clears_tbe: assert property (@(posedge clk) disable iff (!rstN)
    (modeTx && status[0] && hostTxWrite && !nakGuard && !hostModeWr) |=> !status[0]);

  a_r9_guard_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    (modeTx && status[0] && hostTxWrite && nakGuard && !hostModeWr) |=> status[0]);

endmodule

bind scCharEngine scCharChecker uChk (.*);

// File: tb/tb_scCharEngine.sv
module tb_scCharEngine;

  localparam int D = 4;  // clocks per quarter ETU

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] cfgQtrDiv = 10'(D);
  logic       cfgT1 = 1'b0;
  logic [2:0] cfgPeLimit = 3'd2;
  logic       cfgLastChar = 1'b0;
  logic       hostModeWr = 1'b0, hostModeVal = 1'b0;
  logic       hostTxWrite = 1'b0;
  logic [7:0] hostTxData = '0;
  logic       hostRxRead = 1'b0, hostStatusRead = 1'b0;
  logic       cardLow = 1'b0;
  logic       ioDriveLow, modeTx, nakGuard;
  logic [7:0] rxData, status;
  wire        ioLine = ~(cardLow | ioDriveLow);

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  scCharEngine dut (
    .clk(clk), .rstN(rstN), .cfgQtrDiv(cfgQtrDiv), .cfgT1(cfgT1), .cfgPeLimit(cfgPeLimit),
    .cfgLastChar(cfgLastChar), .hostModeWr(hostModeWr), .hostModeVal(hostModeVal),
    .hostTxWrite(hostTxWrite), .hostTxData(hostTxData), .hostRxRead(hostRxRead),
    .hostStatusRead(hostStatusRead), .ioIn(ioLine), .ioDriveLow(ioDriveLow),
    .rxData(rxData), .status(status), .modeTx(modeTx), .nakGuard(nakGuard)
  );

  function automatic logic evenPar(input logic [7:0] b);
    return ^b;
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * D) @(negedge clk);
  endtask

  // Card drives one character; holdQ extra quarters of low line after the parity cell
  task automatic sendChar(input logic [7:0] b, input logic flipPar, input int holdQ);
    logic [9:0] fr;
    fr = {evenPar(b) ^ flipPar, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      cardLow = !fr[k];
      waitQ(1 * 4);
    end
    if (holdQ > 0) begin
      cardLow = 1'b1;
      waitQ(holdQ);
    end
    cardLow = 1'b0;
  endtask

  // Called 40 quarters after the start edge: sample NAK at 44, finish at 50
  task automatic rxTail(output logic sawNak);
    waitQ(4);
    sawNak = ioDriveLow;
    waitQ(6);
  endtask

  task automatic cardRecv(input logic doNak, output logic [7:0] got, output logic parOk);
    logic [9:0] fr;
    int w;
    w = 0;
    while (ioLine && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chkEq("R8 transmission starts", int'(w < 4000), 1);
    waitQ(2);
    for (int k = 0; k < 10; k++) begin
      fr[k] = ioLine;
      if (k < 9) waitQ(4);
    end
    waitQ(3);
    if (doNak) cardLow = 1'b1;
    waitQ(4);
    cardLow = 1'b0;
    waitQ(4);
    got   = fr[8:1];
    parOk = !fr[0] && !(^fr[9:1]);
  endtask

  task automatic popOne();
    hostRxRead = 1'b1;
    @(negedge clk);
    hostRxRead = 1'b0;
  endtask

  task automatic readStatus();
    hostStatusRead = 1'b1;
    @(negedge clk);
    hostStatusRead = 1'b0;
  endtask

  task automatic setMode(input logic v);
    hostModeVal = v;
    hostModeWr  = 1'b1;
    @(negedge clk);
    hostModeWr  = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] b);
    hostTxData  = b;
    hostTxWrite = 1'b1;
    @(negedge clk);
    hostTxWrite = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic       nak, pok;
    logic [7:0] got, b;
    logic [7:0] expQ [8];
    void'($urandom(32'h5EED1234));

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chkEq("R6 status after reset", int'(status), 0);
    chkEq("R2 line released after reset", int'(ioDriveLow), 0);
    chkEq("R8 receive mode after reset", int'(modeTx), 0);
    chkEq("R9 no guard after reset", int'(nakGuard), 0);

    // T=0 receive: rejection, drop, counting
    cfgT1 = 1'b0; cfgPeLimit = 3'd2;
    waitQ(2);
    sendChar(8'hA3, 1'b1, 0);
    rxTail(nak);
    chkEq("R2 NAK driven on bad parity", int'(nak), 1);
    chkEq("R7 flag below limit", int'(status[3]), 0);
    sendChar(8'h5A, 1'b0, 0);
    rxTail(nak);
    chkEq("R2 no NAK on good parity", int'(nak), 0);
    chkEq("R2 bad char dropped, R1 good char received", int'(rxData), 'h5A);
    sendChar(8'h3C, 1'b1, 0);
    waitQ(2);
    chkEq("R7 rx flag not before 42 quarters", int'(status[3]), 0);
    @(negedge clk);
    chkEq("R7 rx flag at 42 quarters", int'(status[3]), 1);
    repeat (8 * D - 1) @(negedge clk);
    popOne();
    readStatus();
    chkEq("R6 read clears flags", int'(status[3:1]), 0);

    // Framing error under T=1
    cfgT1 = 1'b1;
    sendChar(8'hC5, 1'b0, 2);
    rxTail(nak);
    chkEq("R6 framing flag set", int'(status[1]), 1);
    chkEq("R1 char with late stop still stored", int'(rxData), 'hC5);
    popOne();
    readStatus();
    chkEq("R6 framing flag cleared by read", int'(status[1]), 0);

    // T=1 bad parity stored silently
    sendChar(8'h96, 1'b1, 0);
    rxTail(nak);
    chkEq("R3 no NAK under T1", int'(nak), 0);
    chkEq("R3 no parity flag under T1", int'(status[3]), 0);
    chkEq("R3 bad char stored under T1", int'(rxData), 'h96);
    popOne();

    // Random fill past depth
    for (int i = 0; i < 9; i++) begin
      b = 8'($urandom);
      if (i < 8) expQ[i] = b;
      sendChar(b, 1'($urandom % 2), 0);
      rxTail(nak);
      if (i == 7) begin
        chkEq("R4 full flag at 8 entries", int'(status[0]), 1);
        chkEq("R5 no overrun yet", int'(status[2]), 0);
      end
    end
    chkEq("R5 overrun flag", int'(status[2]), 1);
    for (int i = 0; i < 8; i++) begin
      chkEq("R4 queue order", int'(rxData), int'(expQ[i]));
      popOne();
      if (i == 0) chkEq("R4 full flag clears on pop", int'(status[0]), 0);
    end
    readStatus();

    // Transmit under T=0
    cfgT1 = 1'b0; cfgPeLimit = 3'd1;
    setMode(1'b1);
    chkEq("R8 buffer empty on entering tx", int'(status[0]), 1);
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom);
      writeTx(b);
      chkEq("R8 write clears empty", int'(status[0]), 0);
      cardRecv(1'b0, got, pok);
      chkEq("R1 tx byte", int'(got), int'(b));
      chkEq("R1 tx parity and start", int'(pok), 1);
      chkEq("R8 empty after character", int'(status[0]), 1);
    end
    chkEq("R7 no flag without NAK", int'(status[3]), 0);

    // Card rejection and guard window
    writeTx(8'h71);
    cardRecv(1'b1, got, pok);
    chkEq("R9 guard active after NAK", int'(nakGuard), 1);
    chkEq("R7 tx flag after NAK", int'(status[3]), 1);
    writeTx(8'h22);
    chkEq("R9 write ignored in guard", int'(status[0]), 1);
    waitQ(60);
    chkEq("R9 guard ends", int'(nakGuard), 0);
    chkEq("R9 nothing sent from ignored write", int'(status[0]), 1);
    readStatus();
    writeTx(8'h71);
    cardRecv(1'b0, got, pok);
    chkEq("R9 resend after window", int'(got), 'h71);

    // Last character and software clear
    cfgLastChar = 1'b1;
    writeTx(8'hE1);
    cardRecv(1'b0, got, pok);
    chkEq("R10 mode cleared after last char", int'(modeTx), 0);
    chkEq("R10 empty not set after last char", int'(status[0]), 0);
    cfgLastChar = 1'b0;
    setMode(1'b1);
    chkEq("R10 empty set again", int'(status[0]), 1);
    setMode(1'b0);
    chkEq("R10 software clear of mode", int'(modeTx), 0);
    chkEq("R10 empty cleared by software", int'(status[0]), 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule